// File: doc/BRIEF.md
# Multifunction Integer ALU

This block is the combinational arithmetic and logic unit of a 32-bit datapath. It takes two operands and a small set of control codes, and it returns one result word with two flags. A two-bit group select picks one of four result sources: an externally supplied shift result, a signed compare, the adder/subtractor, or a four-function bitwise unit. The shifter lives in a separate block, and its output arrives on a dedicated input port that this block only routes.

The adder/subtractor adds B, or adds the bitwise inverse of B with a carry-in of one. The signed compare is built on that subtractor. It takes the sign of the difference and XORs it with the signed overflow indication, so the answer stays correct when the subtraction overflows. The overflow flag is always computed from the adder, whichever group is selected. The zero flag looks at the final selected word.

The block has no registers and no clock. The controlling pipeline or state machine samples its outputs in the same cycle that it presents the inputs. The word width is a parameter, with a default of 32.

Top module: `mfalu`

## Requirements
- R1: With group code 00, `result` equals `shift_res` bit for bit.
- R2: With group code 10 and `sub_en` = 0, `result` is `in_a + in_b` modulo 2^W.
- R3: With group code 10 and `sub_en` = 1, `result` is `in_a - in_b` modulo 2^W, formed by inverting B and adding a carry-in of one.
- R4: With group code 11, `logic_op` selects the bitwise function: 00 = AND, 01 = OR, 10 = NOR, 11 = XOR.
- R5: With group code 01, bit 0 of `result` is 1 exactly when `in_a` is less than `in_b` as two's-complement numbers, including when the difference overflows. All higher bits of `result` are 0.
- R6: With group code 01, the adder subtracts whatever value `sub_en` has.
- R7: `ovf_flag` is 1 exactly when both adder operands (after any inversion of B) share a sign and the sum's sign differs from it. This holds for every group code.
- R8: `zero_flag` is 1 exactly when the final selected `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| shift_res | input | W | Result from the external shifter, routed by group 00 |
| grp_sel | input | 2 | Result group: 00 shift, 01 signed compare, 10 add/sub, 11 bitwise |
| logic_op | input | 2 | Bitwise function: 00 AND, 01 OR, 10 NOR, 11 XOR |
| sub_en | input | 1 | Adder control: 0 add, 1 subtract |
| result | output | W | Selected result word |
| zero_flag | output | 1 | Selected result is zero |
| ovf_flag | output | 1 | Signed overflow of the adder |

## Verification
The bench builds two copies of the block. One uses the default W = 32, and one uses W = 8; both share the control inputs. The 32-bit copy receives directed corner words, such as the most negative and most positive values, their sums and differences, and NOR on complementary halves, followed by several thousand random operand and control mixes. The 8-bit copy makes the sign boundary dense. A sweep of operand A against B values at and around the sign boundary exercises the compare across its overflow region, and the overflow flag under both add and subtract, far more often than random 32-bit words reach them.

// File: rtl/mfalu_pkg.sv
`timescale 1ns/1ps
package mfalu_pkg;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_SLT   = 2'b01,
        GRP_ARITH = 2'b10,
        GRP_LOGIC = 2'b11
    } grp_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_NOR = 2'b10,
        LOP_XOR = 2'b11
    } lop_e;

endpackage

// File: rtl/mfalu_addsub.sv
`timescale 1ns/1ps
module mfalu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide_chk;

    always_comb begin
        b_eff = opb ^ {W{do_sub}};
        sum   = opa + b_eff + W'(do_sub);
        ovf   = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);
    end

    // Cross-check against a sign-extended computation one bit wider
    always_comb begin
        wide_chk = do_sub ? ({opa[MSB], opa} - {opb[MSB], opb})
                          : ({opa[MSB], opa} + {opb[MSB], opb});
        if (!$isunknown({opa, opb, do_sub})) begin
            AST_OVF_WIDE: assert (ovf == (wide_chk[W] != wide_chk[MSB]))
                else $error("overflow disagrees with wide result"); // R7
            if (do_sub && opa == opb) begin
                AST_SUB_SELF: assert (sum == '0)
                    else $error("x - x not zero"); // R3
            end
        end
    end

endmodule

// File: rtl/mfalu_logic.sv
`timescale 1ns/1ps
module mfalu_logic
    import mfalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   op,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (lop_e'(op))
            LOP_AND: y = opa & opb;
            LOP_OR:  y = opa | opb;
            LOP_NOR: y = ~(opa | opb);
            LOP_XOR: y = opa ^ opb;
            default: y = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({opa, opb, op})) begin
            if (lop_e'(op) == LOP_XOR && opa == opb) begin
                AST_XOR_SELF: assert (y == '0)
                    else $error("x ^ x not zero"); // R4
            end
            if (lop_e'(op) == LOP_NOR) begin
                AST_NOR_DISJOINT: assert ((y & (opa | opb)) == '0)
                    else $error("NOR overlaps OR"); // R4
            end
        end
    end

endmodule

// File: rtl/mfalu.sv
`timescale 1ns/1ps
module mfalu
    import mfalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] shift_res,
    input  logic [1:0]   grp_sel,
    input  logic [1:0]   logic_op,
    input  logic         sub_en,
    output logic [W-1:0] result,
    output logic         zero_flag,
    output logic         ovf_flag
);
    localparam int MSB = W - 1;

    grp_e         grp;
    logic         add_sub;
    logic [W-1:0] arith_y;
    logic [W-1:0] logic_y;
    logic         less;

    always_comb begin
        grp     = grp_e'(grp_sel);
        add_sub = sub_en | (grp == GRP_SLT);
    end

    mfalu_addsub #(.W(W)) u_addsub (
        .opa    (in_a),
        .opb    (in_b),
        .do_sub (add_sub),
        .sum    (arith_y),
        .ovf    (ovf_flag)
    );

    mfalu_logic #(.W(W)) u_logic (
        .opa (in_a),
        .opb (in_b),
        .op  (logic_op),
        .y   (logic_y)
    );

    always_comb begin
        less = arith_y[MSB] ^ ovf_flag;
        unique case (grp)
            GRP_SHIFT: result = shift_res;
            GRP_SLT:   result = {{(W-1){1'b0}}, less};
            GRP_ARITH: result = arith_y;
            GRP_LOGIC: result = logic_y;
            default:   result = '0;
        endcase
        zero_flag = (result == '0);
    end

    always_comb begin
        if (!$isunknown({in_a, in_b, shift_res, grp_sel, logic_op, sub_en})) begin
            if (grp == GRP_SHIFT) begin
                AST_SHIFT_PASS: assert (result == shift_res)
                    else $error("shift result not routed"); // R1
            end
            if (grp == GRP_SLT) begin
                AST_SLT_UPPER: assert (result[MSB:1] == '0)
                    else $error("compare upper bits set"); // R5
            end
            if (grp == GRP_SLT && in_a == in_b) begin
                AST_SLT_EQUAL: assert (result == '0)
                    else $error("x < x reported"); // R6
            end
            if (zero_flag && grp == GRP_LOGIC && lop_e'(logic_op) == LOP_NOR) begin
                AST_ZERO_NOR: assert ((in_a | in_b) == '1)
                    else $error("zero flag on NOR without full OR"); // R8
            end
        end
    end

endmodule

// File: tb/tb_mfalu.sv
`timescale 1ns/1ps
module tb_mfalu;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] a32 = '0, b32 = '0, s32 = '0;
    logic [7:0]  a8 = '0, b8 = '0, s8 = '0;
    logic [1:0]  grp = '0, op = '0;
    logic        sub = 1'b0;
    logic [31:0] r32;
    logic [7:0]  r8;
    logic        z32, v32, z8, v8;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    mfalu #(.W(32)) dut (
        .in_a(a32), .in_b(b32), .shift_res(s32), .grp_sel(grp),
        .logic_op(op), .sub_en(sub), .result(r32), .zero_flag(z32), .ovf_flag(v32)
    );

    mfalu #(.W(8)) dut8 (
        .in_a(a8), .in_b(b8), .shift_res(s8), .grp_sel(grp),
        .logic_op(op), .sub_en(sub), .result(r8), .zero_flag(z8), .ovf_flag(v8)
    );

    function automatic void model(input int w, input longint a, input longint b,
                                  input longint sh, input int g, input int o, input bit s,
                                  output longint res, output bit z, output bit v);
        longint mask, half, sa, sb, tr;
        mask = (64'sd1 <<< w) - 1;
        half = 64'sd1 <<< (w - 1);
        sa = (a >= half) ? a - (mask + 1) : a;
        sb = (b >= half) ? b - (mask + 1) : b;
        tr = (s || g == 1) ? sa - sb : sa + sb;
        v = (tr >= half) || (tr < -half);
        case (g)
            0: res = sh & mask;
            1: res = (sa < sb) ? 1 : 0;
            2: res = tr & mask;
            default: begin
                case (o)
                    0: res = a & b;
                    1: res = a | b;
                    2: res = ~(a | b) & mask;
                    default: res = a ^ b;
                endcase
            end
        endcase
        z = (res == 0);
    endfunction

    function automatic string tag_of(input int g, input bit s);
        case (g)
            0: return "R1";
            1: return s ? "R5" : "R6";
            2: return s ? "R3" : "R2";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic apply32(input string tag, input longint a, input longint b, input longint sh,
                           input int g, input int o, input bit s);
        longint er;
        bit ez, ev;
        @(posedge clk);
        #1;
        a32 = a[31:0]; b32 = b[31:0]; s32 = sh[31:0];
        grp = g[1:0]; op = o[1:0]; sub = s;
        @(negedge clk);
        model(32, a & 64'hFFFF_FFFF, b & 64'hFFFF_FFFF, sh, g, o, s, er, ez, ev);
        check(tag, "result32", {32'b0, r32}, er);
        check("R8", "zero32", {63'b0, z32}, {63'b0, ez});
        check("R7", "ovf32", {63'b0, v32}, {63'b0, ev});
    endtask

    task automatic apply8(input string tag, input longint a, input longint b,
                          input int g, input int o, input bit s);
        longint er;
        bit ez, ev;
        @(posedge clk);
        #1;
        a8 = a[7:0]; b8 = b[7:0]; s8 = 8'h5A;
        grp = g[1:0]; op = o[1:0]; sub = s;
        @(negedge clk);
        model(8, a & 255, b & 255, 64'h5A, g, o, s, er, ez, ev);
        check(tag, "result8", {56'b0, r8}, er);
        check("R8", "zero8", {63'b0, z8}, {63'b0, ez});
        check("R7", "ovf8", {63'b0, v8}, {63'b0, ev});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        longint bedge[6];
        // idle state: all inputs zero, shift group
        apply32("R1", 0, 0, 0, 0, 0, 0);
        // R1 routing of shift result
        apply32("R1", 1, 2, 64'hDEADBEEF, 0, 3, 1);
        // R2 additions
        apply32("R2", 5, 7, 0, 2, 0, 0);
        apply32("R2", 64'hFFFFFFFF, 1, 0, 2, 0, 0);
        apply32("R2", 64'h7FFFFFFF, 1, 0, 2, 0, 0);
        apply32("R2", 64'h80000000, 64'h80000000, 0, 2, 0, 0);
        // R3 subtractions
        apply32("R3", 10, 3, 0, 2, 0, 1);
        apply32("R3", 3, 10, 0, 2, 0, 1);
        apply32("R3", 64'h80000000, 1, 0, 2, 0, 1);
        apply32("R3", 64'h12345678, 64'h12345678, 0, 2, 0, 1);
        apply32("R3", 0, 64'h80000000, 0, 2, 0, 1);
        // R4 bitwise unit
        for (int o = 0; o < 4; o++)
            apply32("R4", 64'hF0F000FF, 64'hFF000F0F, 0, 3, o, 0);
        apply32("R4", 64'hFFFF0000, 64'h0000FFFF, 0, 3, 2, 0);
        apply32("R4", 64'hA5A5A5A5, 64'hA5A5A5A5, 0, 3, 3, 0);
        // R5 and R6 compare, with and without sub_en
        for (int s = 0; s < 2; s++) begin
            apply32(s ? "R5" : "R6", 64'hFFFFFFFF, 1, 0, 1, 0, s[0]);
            apply32(s ? "R5" : "R6", 1, 64'hFFFFFFFF, 0, 1, 0, s[0]);
            apply32(s ? "R5" : "R6", 64'h80000000, 64'h7FFFFFFF, 0, 1, 0, s[0]);
            apply32(s ? "R5" : "R6", 64'h7FFFFFFF, 64'h80000000, 0, 1, 0, s[0]);
            apply32(s ? "R5" : "R6", 77, 77, 0, 1, 0, s[0]);
        end
        // R7 overflow reported while another group is selected
        apply32("R7", 64'h7FFFFFFF, 1, 0, 3, 1, 0);
        apply32("R7", 64'h80000000, 1, 64'h1, 0, 0, 1);
        // R8 zero on selected result rather than adder
        apply32("R8", 5, 5, 0, 3, 0, 0);
        apply32("R8", 5, 5, 64'h8, 0, 0, 1);
        // random 32-bit mixes
        for (int i = 0; i < 3000; i++) begin
            longint ra, rb, rs;
            int g, o;
            bit s;
            ra = {32'b0, $urandom()};
            rb = {32'b0, $urandom()};
            rs = {32'b0, $urandom()};
            if (i % 8 == 0) rb = ra;
            g = $urandom_range(0, 3);
            o = $urandom_range(0, 3);
            s = 1'($urandom_range(0, 1));
            apply32(tag_of(g, s), ra, rb, rs, g, o, s);
        end
        // 8-bit sweep around the sign boundary
        bedge = '{0, 1, 127, 128, 129, 255};
        for (int a = 0; a < 256; a += 3) begin
            for (int k = 0; k < 7; k++) begin
                longint bv;
                bv = (k == 6) ? longint'(a) : bedge[k];
                apply8("R5", a, bv, 1, 0, 1);
                apply8("R6", a, bv, 1, 0, 0);
                apply8("R3", a, bv, 2, 0, 1);
                apply8("R2", a, bv, 2, 0, 0);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule